// File: doc/BRIEF.md
# Dual-Buffer Frame Fetch DMA

This block reads frame data out of memory on behalf of a raster display engine. Software describes up to two frame buffers, each as a base word address and an inclusive ceiling word address. While running, the block walks the selected buffer from base to ceiling in bursts, pushes every returned word into the pixel FIFO, and signals completion of each buffer with its own end-of-frame event. In dual mode it ping-pongs between the two buffers. Single mode reuses buffer 0 for every frame.

A load-mode selection lets the block first make one pass over buffer 0 as a palette load before pixel fetching starts, or make only that palette pass and then park. The block also watches the FIFO's read side and flags an underflow when the raster pulls from an empty FIFO. A second consecutive underflow cycle is reported as loss of sync. All addresses are in word units, and each accepted beat advances the address by one word.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset no request is raised, no word is pushed and every event bit is 0.
- R2: Each buffer is fetched from its base to its inclusive ceiling, one word per beat. Returned words are pushed to the FIFO in address order, and a pending request holds its address and length until granted.
- R3: The burst code gives the request length in beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16. Codes above 4 act as 4.
- R4: A burst is shortened so that it never reads beyond the ceiling of the current buffer.
- R5: With dualMode=1 frames alternate buffer 0, buffer 1, buffer 0, and so on. With dualMode=0 every frame uses buffer 0.
- R6: Finishing buffer 0 pulses evt bit 8 and finishing buffer 1 pulses evt bit 9, for one cycle after the last word. At most one of bits 9, 8 and 6 is set at a time.
- R7: loadMode=1 (palette only) fetches base 0 to ceiling 0 once, pulses evt bit 6, then issues no further request until runEn is cleared.
- R8: loadMode=0 performs that palette pass with evt bit 6, then fetches data starting with buffer 0. loadMode=2 (and 3) fetches data only, starting with buffer 0.
- R9: A buffer's base and ceiling are captured when its fetch begins. A rewrite during that fetch leaves the current frame unchanged and takes effect on the buffer's next use.
- R10: While runEn=1, pixPull with fifoEmpty raises evt bit 5 in the same cycle. A second consecutive such cycle also raises evt bit 2. No underflow is reported while runEn=0 or while the FIFO is not empty.
- R11: Clearing runEn lets the burst in flight finish and issues no new request. The next start begins with buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Fetch run enable |
| dualMode | input | 1 | 1 = alternate buffers 0 and 1 |
| burstCode | input | 3 | Burst length code (R3) |
| loadMode | input | 2 | 0 palette then data, 1 palette only, 2 data only |
| base0 | input | ADDR_W | Buffer 0 first word address |
| ceil0 | input | ADDR_W | Buffer 0 last word address (inclusive) |
| base1 | input | ADDR_W | Buffer 1 first word address |
| ceil1 | input | ADDR_W | Buffer 1 last word address (inclusive) |
| memReq | output | 1 | Burst read request |
| memGnt | input | 1 | Request accepted |
| memAddr | output | ADDR_W | Burst start word address |
| memLen | output | MAX_LOG+1 | Burst length in beats |
| rdValid | input | 1 | Read beat valid |
| rdData | input | DATA_W | Read beat data |
| fifoPush | output | 1 | Write strobe into pixel FIFO |
| fifoData | output | DATA_W | Word written into pixel FIFO |
| pixPull | input | 1 | Raster reads the FIFO this cycle |
| fifoEmpty | input | 1 | Pixel FIFO is empty |
| evt | output | 10 | Event pulses: 9 end of buffer 1, 8 end of buffer 0, 6 palette done, 5 underflow, 2 sync lost |

## Verification
The hardest situations to reach from the ports are a descriptor rewrite that lands in the middle of a buffer's fetch and a stop that lands in the middle of a burst. Both depend on where the fetch stands at that moment. The stimulus ties them to the scoreboard's progress. It waits until a given number of words have been consumed, rewrites buffer 0 or drops runEn in that same cycle, and then checks that the frame in flight or the burst in flight finishes unchanged. The new descriptor must show up only on the next pass over that buffer.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_REQ, ST_DATA, ST_NEXT, ST_HALT
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBuf;  // capture descriptor
    logic selBuf;   // which descriptor
    logic grant;    // burst accepted
    logic beat;     // one word received
  } fetchStrb_t;

  localparam logic [1:0] LM_PAL_DATA = 2'd0;
  localparam logic [1:0] LM_PAL_ONLY = 2'd1;

  localparam int EV_EOF0   = 8;
  localparam int EV_EOF1   = 9;
  localparam int EV_PALDN  = 6;
  localparam int EV_UNDER  = 5;
  localparam int EV_SYNCLS = 2;
endpackage

// File: rtl/ffd_datapath.sv
module ffd_datapath import ffd_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrb_t        strb,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] ceil0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] ceil1,
  input  logic [2:0]        burstCode,
  output logic [ADDR_W-1:0] curAddr,
  output logic [MAX_LOG:0]  burstLen,
  output logic              lastBeat,
  output logic              endSeen
);
  localparam int LEN_W = MAX_LOG + 1;

  logic [ADDR_W-1:0] curCeil;
  logic [LEN_W-1:0]  beatsLeft;
  logic [ADDR_W:0]   remain;
  logic [ADDR_W:0]   maxLen;
  logic [2:0]        codeClamp;

  always_comb begin
    codeClamp = (int'(burstCode) > MAX_LOG) ? 3'(MAX_LOG) : burstCode;
    maxLen    = (ADDR_W+1)'(1) << codeClamp;
    remain    = {1'b0, curCeil} - {1'b0, curAddr} + (ADDR_W+1)'(1);
    burstLen  = (remain < maxLen) ? remain[LEN_W-1:0] : maxLen[LEN_W-1:0];
  end

  assign lastBeat = (beatsLeft == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curCeil   <= '0;
      beatsLeft <= '0;
      endSeen   <= 1'b0;
    end else begin
      if (strb.loadBuf) begin
        curAddr <= strb.selBuf ? base1 : base0;
        curCeil <= strb.selBuf ? ceil1 : ceil0;
        endSeen <= 1'b0;
      end
      if (strb.grant) beatsLeft <= burstLen;
      if (strb.beat) begin
        curAddr   <= curAddr + ADDR_W'(1);
        beatsLeft <= beatsLeft - LEN_W'(1);
        if (curAddr == curCeil) endSeen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ffd_control.sv
module ffd_control import ffd_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       dualMode,
  input  logic [1:0] loadMode,
  input  logic       memGnt,
  input  logic       rdValid,
  input  logic       lastBeat,
  input  logic       endSeen,
  input  logic       pixPull,
  input  logic       fifoEmpty,
  output fetchStrb_t strb,
  output logic       memReq,
  output logic       fifoPush,
  output logic [9:0] evt
);
  fetchState_t state, stateNx;
  logic curBuf, curBufNx;
  logic palPhase, palPhaseNx;
  logic palOnly;
  logic prevUnder, under;

  assign under = runEn && pixPull && fifoEmpty;

  always_comb begin
    stateNx    = state;
    curBufNx   = curBuf;
    palPhaseNx = palPhase;
    strb       = '0;
    memReq     = 1'b0;
    fifoPush   = 1'b0;
    evt        = '0;
    evt[EV_UNDER]  = under;
    evt[EV_SYNCLS] = under && prevUnder;
    case (state)
      ST_IDLE: if (runEn) begin
        stateNx    = ST_LOAD;
        curBufNx   = 1'b0;
        palPhaseNx = (loadMode == LM_PAL_DATA) || (loadMode == LM_PAL_ONLY);
      end
      ST_LOAD: begin
        strb.loadBuf = runEn;
        strb.selBuf  = palPhase ? 1'b0 : curBuf;
        stateNx      = runEn ? ST_REQ : ST_IDLE;
      end
      ST_REQ: begin
        memReq = 1'b1;
        if (memGnt) begin
          strb.grant = 1'b1;
          stateNx    = ST_DATA;
        end
      end
      ST_DATA: if (rdValid) begin
        strb.beat = 1'b1;
        fifoPush  = 1'b1;
        if (lastBeat) stateNx = ST_NEXT;
      end
      ST_NEXT: begin
        if (endSeen) begin
          if (palPhase) begin
            evt[EV_PALDN] = 1'b1;
            palPhaseNx    = 1'b0;
            curBufNx      = 1'b0;
            stateNx       = palOnly ? ST_HALT : ST_LOAD;
          end else begin
            evt[curBuf ? EV_EOF1 : EV_EOF0] = 1'b1;
            curBufNx = dualMode ? ~curBuf : 1'b0;
            stateNx  = ST_LOAD;
          end
        end else begin
          stateNx = ST_REQ;
        end
        if (!runEn) begin
          stateNx  = ST_IDLE;
          curBufNx = 1'b0;
        end
      end
      ST_HALT: if (!runEn) stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curBuf    <= 1'b0;
      palPhase  <= 1'b0;
      palOnly   <= 1'b0;
      prevUnder <= 1'b0;
    end else begin
      state     <= stateNx;
      curBuf    <= curBufNx;
      palPhase  <= palPhaseNx;
      prevUnder <= under;
      if (state == ST_IDLE && runEn) palOnly <= (loadMode == LM_PAL_ONLY);
    end
  end
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma import ffd_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              dualMode,
  input  logic [2:0]        burstCode,
  input  logic [1:0]        loadMode,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] ceil0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] ceil1,
  output logic              memReq,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [MAX_LOG:0]  memLen,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              fifoPush,
  output logic [DATA_W-1:0] fifoData,
  input  logic              pixPull,
  input  logic              fifoEmpty,
  output logic [9:0]        evt
);
  fetchStrb_t strb;
  logic lastBeat, endSeen;

  ffd_datapath #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .burstCode(burstCode), .curAddr(memAddr), .burstLen(memLen),
    .lastBeat(lastBeat), .endSeen(endSeen)
  );

  ffd_control u_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dualMode(dualMode),
    .loadMode(loadMode), .memGnt(memGnt), .rdValid(rdValid),
    .lastBeat(lastBeat), .endSeen(endSeen), .pixPull(pixPull),
    .fifoEmpty(fifoEmpty), .strb(strb), .memReq(memReq),
    .fifoPush(fifoPush), .evt(evt)
  );

  assign fifoData = rdData;
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LOG = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic [MAX_LOG:0]  memLen,
  input logic              fifoPush,
  input logic [9:0]        evt
);
  // R2: an unaccepted request keeps its address and length
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memLen));

  // R3: request length stays within 1..max burst
  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memLen != '0) && (int'(memLen) <= (1 << MAX_LOG)));

  // R6: frame/palette events are exclusive and are not followed by a push
  assert_evt_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evt[9], evt[8], evt[6]}));
  assert_evt_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evt[9] || evt[8] || evt[6]) |=> !fifoPush);

  // R10: sync lost only follows an underflow cycle
  assert_sync_after_under_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt[2] |-> evt[5] && $past(evt[5]));

  // R11: stopped and idle on the bus stays idle on the bus
  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !memReq |=> !memReq);
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .memReq(memReq), .memGnt(memGnt),
  .memAddr(memAddr), .memLen(memLen), .fifoPush(fifoPush), .evt(evt)
);

// File: tb/frame_fetch_dma_tb.sv
`timescale 1ns/1ps
module frame_fetch_dma_tb;
  localparam int KB = 0, KW = 1, KE = 2;
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
  } item_t;

  logic clk = 0, rstN = 0;
  logic runEn = 0, dualMode = 0, memGnt = 0, rdValid = 0, pixPull = 0, fifoEmpty = 0;
  logic [2:0] burstCode = 0;
  logic [1:0] loadMode = 2;
  logic [31:0] base0 = 0, ceil0 = 0, base1 = 0, ceil1 = 0, rdData = 0;
  logic memReq, fifoPush;
  logic [31:0] memAddr, fifoData;
  logic [4:0] memLen;
  logic [9:0] evt;

  int checks = 0, fails = 0;
  int pushCnt = 0, grantCnt = 0, wordPops = 0;
  bit sbOn = 0;
  item_t sbq[$];
  int pend = 0;
  logic [31:0] mAddr = 0;

  always #4 clk = ~clk;

  frame_fetch_dma u_dut (.*);

  // memory model
  always @(negedge clk) begin
    if (pend > 0) begin
      rdValid <= 1; rdData <= mAddr; mAddr <= mAddr + 1; pend <= pend - 1;
    end else rdValid <= 0;
    if (memGnt) memGnt <= 0;
    else if (memReq && pend == 0) begin
      memGnt <= 1; mAddr <= memAddr; pend <= int'(memLen);
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic popCheck(int kind, logic [31:0] a, logic [31:0] b);
    item_t it;
    string tag;
    tag = (kind == KB) ? "R4 burst" : (kind == KW) ? "R2 word" : "R6 event";
    if (sbq.size() == 0) begin
      chk(0, tag, "unexpected item", a, 0);
      return;
    end
    it = sbq.pop_front();
    chk(it.kind == 2'(kind) && it.a == a && it.b == b, tag, "mismatch", a, it.a);
    if (kind == KB) chk(it.b == b, "R3", "burst length", b, it.b);
    if (kind == KW) wordPops++;
  endtask

  // monitor
  initial forever begin
    @(negedge clk); #1;
    if (memReq && memGnt) begin
      grantCnt++;
      if (sbOn) popCheck(KB, memAddr, 32'(memLen));
    end
    if (fifoPush) begin
      pushCnt++;
      if (sbOn) popCheck(KW, fifoData, 0);
    end
    if (sbOn && (evt & 10'b1101000000) != 0) popCheck(KE, 32'(evt & 10'b1101000000), 0);
  end

  function automatic int blen(int code, logic [31:0] a, logic [31:0] c);
    int m, r;
    m = 1 << ((code > 4) ? 4 : code);
    r = int'(c - a) + 1;
    return (r < m) ? r : m;
  endfunction

  task automatic expFrame(logic [31:0] b, logic [31:0] c, int code, int mask);
    logic [31:0] a;
    a = b;
    while (a <= c) begin
      int l;
      l = blen(code, a, c);
      sbq.push_back('{2'(KB), a, 32'(l)});
      for (int i = 0; i < l; i++) sbq.push_back('{2'(KW), a + 32'(i), 32'd0});
      a = a + 32'(l);
    end
    sbq.push_back('{2'(KE), 32'(mask), 32'd0});
  endtask

  task automatic drain(string req);
    int n;
    n = 0;
    while (sbq.size() != 0 && n < 3000) begin @(negedge clk); #1; n++; end
    runEn = 0;
    chk(sbq.size() == 0, req, "scoreboard not drained", sbq.size(), 0);
    sbq.delete();
    repeat (30) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int g0, p0;
    repeat (3) @(negedge clk);
    #1;
    chk(memReq == 0 && fifoPush == 0 && evt == 0, "R1", "reset outputs", {memReq, fifoPush, evt}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(memReq == 0 && evt == 0, "R1", "idle after reset", {memReq, evt}, 0);
    sbOn = 1;

    // T2: single buffer, data only, burst 8 (R2 R3 R4 R5 R6)
    dualMode = 0; burstCode = 3; loadMode = 2;
    base0 = 32'h100; ceil0 = 32'h113; base1 = 32'hF00; ceil1 = 32'hF03;
    expFrame(base0, ceil0, 3, 1 << 8);
    expFrame(base0, ceil0, 3, 1 << 8);
    runEn = 1;
    drain("R5");

    // T3: dual with mid-fetch rewrite of buffer 0 (R5 R6 R9)
    dualMode = 1; burstCode = 2; loadMode = 2;
    base0 = 32'h200; ceil0 = 32'h209; base1 = 32'h300; ceil1 = 32'h305;
    expFrame(32'h200, 32'h209, 2, 1 << 8);
    expFrame(32'h300, 32'h305, 2, 1 << 9);
    expFrame(32'h400, 32'h403, 2, 1 << 8);
    wordPops = 0;
    runEn = 1;
    while (wordPops < 2) begin @(negedge clk); #1; end
    base0 = 32'h400; ceil0 = 32'h403;   // R9 rewrite during fetch
    drain("R9");

    // T3b: restart begins at buffer 0 (R11)
    expFrame(32'h400, 32'h403, 2, 1 << 8);
    runEn = 1;
    drain("R11");

    // T4: palette only (R7)
    dualMode = 1; burstCode = 1; loadMode = 1;
    base0 = 32'h500; ceil0 = 32'h505;
    expFrame(32'h500, 32'h505, 1, 1 << 6);
    runEn = 1;
    while (sbq.size() != 0) begin @(negedge clk); #1; end
    g0 = grantCnt;
    repeat (40) @(negedge clk);
    #1;
    chk(memReq == 0 && grantCnt == g0, "R7", "requests after palette done", grantCnt - g0, 0);
    runEn = 0;
    repeat (10) @(negedge clk);

    // T5: palette then data, dual (R8)
    loadMode = 0; burstCode = 2;
    base0 = 32'h510; ceil0 = 32'h515; base1 = 32'h520; ceil1 = 32'h522;
    expFrame(32'h510, 32'h515, 2, 1 << 6);
    expFrame(32'h510, 32'h515, 2, 1 << 8);
    expFrame(32'h520, 32'h522, 2, 1 << 9);
    runEn = 1;
    drain("R8");

    // T6: burst code 0 and code 4, truncation (R3 R4)
    dualMode = 0; loadMode = 2; burstCode = 0;
    base0 = 32'h700; ceil0 = 32'h702;
    expFrame(base0, ceil0, 0, 1 << 8);
    runEn = 1;
    drain("R3");
    burstCode = 4; base0 = 32'h800; ceil0 = 32'h813;
    expFrame(base0, ceil0, 4, 1 << 8);
    runEn = 1;
    drain("R4");
    burstCode = 7; base0 = 32'h820; ceil0 = 32'h83F;
    expFrame(base0, ceil0, 7, 1 << 8);
    runEn = 1;
    drain("R3");

    // T7: stop in the middle of a burst (R11)
    sbOn = 0;
    burstCode = 4; base0 = 32'h900; ceil0 = 32'h93F;
    p0 = pushCnt; g0 = grantCnt;
    runEn = 1;
    while (pushCnt - p0 < 3) begin @(negedge clk); #1; end
    runEn = 0;
    repeat (60) @(negedge clk);
    #1;
    chk(pushCnt - p0 == 16, "R11", "words after stop", pushCnt - p0, 16);
    chk(grantCnt - g0 == 1, "R11", "bursts after stop", grantCnt - g0, 1);

    // T8: underflow and sync lost (R10)
    @(negedge clk);
    pixPull = 1; fifoEmpty = 1; #1;
    chk(evt[5] == 0, "R10", "underflow while stopped", evt[5], 0);
    @(negedge clk);
    runEn = 1; #1;
    chk(evt[5] == 1 && evt[2] == 0, "R10", "first underflow", {evt[5], evt[2]}, 2'b10);
    @(negedge clk); #1;
    chk(evt[5] == 1 && evt[2] == 1, "R10", "sync lost", {evt[5], evt[2]}, 2'b11);
    @(negedge clk);
    fifoEmpty = 0; #1;
    chk(evt[5] == 0 && evt[2] == 0, "R10", "pull from non-empty", {evt[5], evt[2]}, 0);
    @(negedge clk);
    pixPull = 0; runEn = 0;
    repeat (60) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule